// File: doc/BRIEF.md
# Scan Cycle Time Supervisor

This block watches the scan loop of a small sequencing controller. A start strobe opens each scan and an end strobe closes it. While a scan is open the block counts pulses of a 100 µs timebase. A long scan raises an alarm that does not stop the controller. A much longer scan latches a fatal stop: the run indicator goes dark and the output-enable drops, which forces every controller output off.

The block can also keep short scans from being too short. When the end strobe comes before a programmed minimum of M timebase ticks, the block keeps counting until the minimum is reached. It then issues a one-cycle permit that allows the next scan to begin. The sequencer waits for this permit before it raises the next start strobe.

To leave the fatal state, the controller is taken out of run mode and a clear is given. That clear also removes the sticky alarm. The parameter PAD_EN selects one of two variants at elaboration. One variant has padding. The other issues the permit as soon as the end strobe arrives.

Top module: `scan_cycle_supervisor`

## Requirements
- R1: The tick count is reset to 0 when a scan start is accepted. It then rises by one on each clock that has `tick`=1 while a scan is open, and it holds at 2**CNT_W-1 rather than wrapping.
- R2: `scan_start` is accepted only while the block is idle, `run_mode`=1 and `fatal`=0. Otherwise it is ignored: no scan opens and no permit follows.
- R3: If `scan_end` arrives while the count T is at least `min_cycle` M, `next_permit` is high for exactly one clock, on the clock right after the end strobe.
- R4: If T < M, the scan is padded. With a tick on every clock after the end strobe, `next_permit` pulses M-T+1 clocks after the end strobe.
- R5: `alarm` is set on the clock after an open scan's count reaches ALARM_TICKS (default 1000, that is 100 ms). It stays set, `run_ind` stays 1 and the permit is still issued.
- R6: When an open scan's count exceeds FATAL_TICKS (default 1300), `fatal` goes to 1, `run_ind` and `out_en` go to 0, and no permit is issued. This outcome wins over a `scan_end` in the same clock.
- R7: `fatal` and `alarm` stay latched while `clear` is given with `run_mode`=1. A `clear` with `run_mode`=0 drops both of them and returns the block to idle.
- R8: After reset, `alarm`=0, `fatal`=0, `out_en`=1, `next_permit`=0, and `run_ind` follows `run_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 100 µs timebase pulse, one clock wide |
| scan_start | input | 1 | Start-of-scan strobe |
| scan_end | input | 1 | End-of-scan strobe |
| run_mode | input | 1 | 1 = run mode, 0 = programming mode |
| clear | input | 1 | Error clear, acted on only when run_mode is 0 |
| min_cycle | input | MIN_W | Minimum scan length M, in ticks |
| alarm | output | 1 | Sticky long-scan alarm |
| fatal | output | 1 | Latched fatal error indicator |
| run_ind | output | 1 | Run indicator |
| out_en | output | 1 | Output enable; 0 forces all outputs off |
| next_permit | output | 1 | One-clock next-scan permit |

## Verification
Two outcomes can fall in the same clock: the end of a scan, which asks for a permit, and the crossing of the fatal threshold. The bench provokes this by ticking exactly FATAL_TICKS+1 times and raising `scan_end` on the very clock whose count first exceeds the limit. The expected result is a latched `fatal`, a low `out_en` and no permit. Scans of exactly FATAL_TICKS ticks, and scans of one tick more that end later, bracket this case. Random scan lengths and minimums are compared against a bench function that gives the permit delay.

// File: rtl/scs_pkg.sv
package scs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_PAD  = 2'd2,
      ST_STOP = 2'd3
   } scs_state_t;
endpackage

// File: rtl/scs_tick_counter.sv
module scs_tick_counter #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (en && tick && (cnt != CNT_MAX))
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/scs_threshold.sv
module scs_threshold #(
   parameter int CNT_W       = 11,
   parameter int ALARM_TICKS = 1000,
   parameter int FATAL_TICKS = 1300
) (
   input  logic             active,
   input  logic [CNT_W-1:0] cnt,
   output logic             over_alarm,
   output logic             over_fatal
);
   localparam logic [CNT_W-1:0] ALARM_LIM = CNT_W'(ALARM_TICKS);
   localparam logic [CNT_W-1:0] FATAL_LIM = CNT_W'(FATAL_TICKS);

   always_comb begin
      over_alarm = active && (cnt >= ALARM_LIM);
      over_fatal = active && (cnt >  FATAL_LIM);
   end
endmodule

// File: rtl/scs_min_gate.sv
module scs_min_gate #(
   parameter int CNT_W  = 11,
   parameter int MIN_W  = 8,
   parameter bit PAD_EN = 1'b1
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [MIN_W-1:0] min_cycle,
   output logic             min_met
);
   generate
      if (PAD_EN) begin : g_pad
         logic [CNT_W-1:0] min_ext;
         always_comb begin
            min_ext = CNT_W'(min_cycle);
            min_met = (cnt >= min_ext);
         end
      end else begin : g_nopad
         logic [CNT_W+MIN_W-1:0] unused_bits;
         always_comb begin
            unused_bits = {cnt, min_cycle};
            min_met = 1'b1 | (&unused_bits);
         end
      end
   endgenerate
endmodule

// File: rtl/scan_cycle_supervisor.sv
module scan_cycle_supervisor
   import scs_pkg::*;
#(
   parameter int CNT_W       = 11,
   parameter int MIN_W       = 8,
   parameter int ALARM_TICKS = 1000,
   parameter int FATAL_TICKS = 1300,
   parameter bit PAD_EN      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             scan_start,
   input  logic             scan_end,
   input  logic             run_mode,
   input  logic             clear,
   input  logic [MIN_W-1:0] min_cycle,
   output logic             alarm,
   output logic             fatal,
   output logic             run_ind,
   output logic             out_en,
   output logic             next_permit
);
   localparam int CNT_TOP = (1 << CNT_W) - 1;

   generate
      if (ALARM_TICKS >= FATAL_TICKS) begin : g_bad_order
         $error("ALARM_TICKS must be below FATAL_TICKS");
      end
      if (FATAL_TICKS >= CNT_TOP) begin : g_bad_width
         $error("CNT_W too small for FATAL_TICKS");
      end
      if (MIN_W > CNT_W) begin : g_bad_min
         $error("MIN_W must not exceed CNT_W");
      end
   endgenerate

   scs_state_t       state_q, state_d;
   logic [CNT_W-1:0] cnt_q;
   logic             alarm_q, fatal_q, permit_q;
   logic             alarm_d, fatal_d, permit_d;
   logic             active, start_acc, clear_ok;
   logic             over_alarm, over_fatal, min_met;

   assign active    = (state_q == ST_SCAN) || (state_q == ST_PAD);
   assign clear_ok  = clear && !run_mode;
   assign start_acc = (state_q == ST_IDLE) && scan_start && run_mode &&
                      !fatal_q && !clear_ok;

   scs_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_acc),
      .en    (active),
      .tick  (tick),
      .cnt   (cnt_q)
   );

   scs_threshold #(
      .CNT_W       (CNT_W),
      .ALARM_TICKS (ALARM_TICKS),
      .FATAL_TICKS (FATAL_TICKS)
   ) u_thr (
      .active     (active),
      .cnt        (cnt_q),
      .over_alarm (over_alarm),
      .over_fatal (over_fatal)
   );

   scs_min_gate #(
      .CNT_W  (CNT_W),
      .MIN_W  (MIN_W),
      .PAD_EN (PAD_EN)
   ) u_min (
      .cnt       (cnt_q),
      .min_cycle (min_cycle),
      .min_met   (min_met)
   );

   always_comb begin
      state_d  = state_q;
      alarm_d  = alarm_q | over_alarm;
      fatal_d  = fatal_q;
      permit_d = 1'b0;
      if (clear_ok) begin
         state_d = ST_IDLE;
         alarm_d = 1'b0;
         fatal_d = 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_acc) state_d = ST_SCAN;
            ST_SCAN: begin
               if (over_fatal) begin
                  state_d = ST_STOP;
                  fatal_d = 1'b1;
               end else if (scan_end) begin
                  if (min_met) begin
                     state_d  = ST_IDLE;
                     permit_d = 1'b1;
                  end else begin
                     state_d = ST_PAD;
                  end
               end
            end
            ST_PAD: begin
               if (over_fatal) begin
                  state_d = ST_STOP;
                  fatal_d = 1'b1;
               end else if (min_met) begin
                  state_d  = ST_IDLE;
                  permit_d = 1'b1;
               end
            end
            ST_STOP: state_d = ST_STOP;
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         alarm_q  <= 1'b0;
         fatal_q  <= 1'b0;
         permit_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         alarm_q  <= alarm_d;
         fatal_q  <= fatal_d;
         permit_q <= permit_d;
      end
   end

   assign alarm       = alarm_q;
   assign fatal       = fatal_q;
   assign next_permit = permit_q;
   assign out_en      = !fatal_q;
   assign run_ind     = run_mode && !fatal_q;
endmodule

// File: rtl/scs_checker.sv
module scs_checker
   import scs_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fatal,
   input logic             alarm,
   input logic             next_permit,
   input logic             clear,
   input logic             run_mode,
   input logic             scan_start,
   input logic             start_acc,
   input logic [CNT_W-1:0] cnt,
   input scs_state_t       state
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // R1: the count holds at its top value instead of wrapping
   assert_cnt_saturates_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX) && !start_acc |=> (cnt == CNT_MAX));

   // R2: a start strobe during a fatal stop opens no scan
   assert_no_start_in_fatal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fatal && scan_start |=> (state != ST_SCAN));

   // R3: the permit is a single-clock pulse
   assert_permit_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      next_permit |=> !next_permit);

   // R5: the alarm stays set until a valid clear
   assert_alarm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      alarm && !(clear && !run_mode) |=> alarm);

   // R6: no permit while the fatal stop holds
   assert_fatal_blocks_permit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |-> !next_permit);

   // R7: the fatal state stays latched until a clear outside run mode
   assert_fatal_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fatal && !(clear && !run_mode) |=> fatal);
endmodule

bind scan_cycle_supervisor scs_checker #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fatal       (fatal),
   .alarm       (alarm),
   .next_permit (next_permit),
   .clear       (clear),
   .run_mode    (run_mode),
   .scan_start  (scan_start),
   .start_acc   (start_acc),
   .cnt         (cnt_q),
   .state       (state_q)
);

// File: tb/scan_cycle_supervisor_tb.sv
module scan_cycle_supervisor_tb;
   localparam int ALARM_T = 1000;
   localparam int FATAL_T = 1300;
   localparam int WAIT_LIM = 300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, scan_start = 1'b0, scan_end = 1'b0;
   logic       run_mode = 1'b1, clear = 1'b0;
   logic [7:0] min_cycle = 8'd0;
   logic       alarm, fatal, run_ind, out_en, next_permit;

   int checks = 0, errors = 0;
   int cycles = 0;
   bit exp_alarm = 1'b0;

   always #2.5 clk = ~clk;

   scan_cycle_supervisor u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .scan_start(scan_start),
      .scan_end(scan_end), .run_mode(run_mode), .clear(clear),
      .min_cycle(min_cycle), .alarm(alarm), .fatal(fatal),
      .run_ind(run_ind), .out_en(out_en), .next_permit(next_permit)
   );

   function automatic int exp_wait(int t, int m);
      return (t >= m) ? 0 : (m - t + 1);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One scan: T ticks, then an end strobe, then ticks on every clock
   task automatic run_scan(int t, int m, string req, output int waited);
      @(negedge clk);
      min_cycle  = m[7:0];
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      tick = 1'b1;
      for (int i = 0; i < t; i++) @(negedge clk);
      tick = 1'b0;
      scan_end = 1'b1;
      @(negedge clk);
      scan_end = 1'b0;
      tick = 1'b1;
      waited = 0;
      while (!next_permit && waited < WAIT_LIM) begin
         @(negedge clk);
         waited++;
      end
      tick = 1'b0;
      if (next_permit) begin
         @(negedge clk);
         check({req, " permit single pulse"}, next_permit, 0);
      end
   endtask

   task automatic do_clear(bit in_run);
      @(negedge clk);
      run_mode = in_run;
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      run_mode = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      while (cycles < 180000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=%0d expected<180000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int w;
      void'($urandom(32'h5CA7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 alarm", alarm, 0);
      check("R8 fatal", fatal, 0);
      check("R8 out_en", out_en, 1);
      check("R8 permit", next_permit, 0);
      check("R8 run_ind", run_ind, 1);

      run_scan(5, 0, "R3", w);    check("R3 T>M wait", w, exp_wait(5, 0));
      run_scan(10, 10, "R3", w);  check("R3 T=M wait", w, exp_wait(10, 10));
      run_scan(9, 10, "R4", w);   check("R4 pad by one", w, exp_wait(9, 10));
      run_scan(0, 255, "R4", w);  check("R4 pad full", w, exp_wait(0, 255));
      run_scan(999, 3, "R5", w);  check("R5 below alarm", alarm, 0);
      run_scan(1000, 3, "R5", w);
      check("R5 alarm set", alarm, 1);
      check("R5 permit still given", w, 0);
      check("R5 run_ind kept", run_ind, 1);
      exp_alarm = 1'b1;

      do_clear(1'b1);
      check("R7 clear in run keeps alarm", alarm, 1);
      do_clear(1'b0);
      check("R7 clear out of run drops alarm", alarm, 0);
      exp_alarm = 1'b0;

      // R2: start strobe outside run mode is ignored
      @(negedge clk);
      run_mode = 1'b0;
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      tick = 1'b1;
      repeat (4) @(negedge clk);
      tick = 1'b0;
      scan_end = 1'b1;
      @(negedge clk);
      scan_end = 1'b0;
      w = 0;
      repeat (4) begin
         if (next_permit) w++;
         @(negedge clk);
      end
      check("R2 start ignored outside run", w, 0);
      run_mode = 1'b1;

      // R1 and R4 with random lengths
      for (int k = 0; k < 20; k++) begin
         int t, m;
         t = $urandom_range(1250, 0);
         m = $urandom_range(255, 0);
         run_scan(t, m, "R1", w);
         check("R1 R4 random wait", w, exp_wait(t, m));
         if (t >= ALARM_T) exp_alarm = 1'b1;
         check("R5 random alarm", alarm, int'(exp_alarm));
         if (k % 5 == 4) begin
            do_clear(1'b0);
            exp_alarm = 1'b0;
         end
      end
      do_clear(1'b0);

      run_scan(FATAL_T, 0, "R6", w);
      check("R6 at limit no fatal", fatal, 0);
      check("R6 at limit permit", w, 0);
      check("R6 at limit alarm", alarm, 1);

      // Fatal crossing in the same clock as the end strobe
      run_scan(FATAL_T + 1, 0, "R6", w);
      check("R6 collision fatal", fatal, 1);
      check("R6 collision no permit", w, WAIT_LIM);
      check("R6 out_en off", out_en, 0);
      check("R6 run_ind off", run_ind, 0);

      run_scan(3, 0, "R2", w);
      check("R2 start ignored in fatal", w, WAIT_LIM);
      do_clear(1'b1);
      check("R7 clear in run keeps fatal", fatal, 1);
      do_clear(1'b0);
      check("R7 fatal cleared", fatal, 0);
      check("R7 out_en back", out_en, 1);
      check("R7 alarm cleared", alarm, 0);
      run_scan(7, 2, "R1", w);
      check("R1 scan after clear", w, 0);

      run_scan(1500, 0, "R6", w);
      check("R6 fatal mid scan", fatal, 1);
      check("R6 mid scan no permit", w, WAIT_LIM);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule